// File: doc/BRIEF.md
# Flash command interface controller

This block is a synchronous, cycle-based model of the command front end of a boot-block NOR flash. Software issues bus write cycles that carry an address and a 16-bit word. The block turns these cycles into commands. Some commands take one cycle. Erase and word write take two cycles, a setup cycle and then a second cycle. The commands choose what a read returns (array contents, the status register, or identifier codes) and start an internal program/erase engine. The engine runs for a fixed number of clock cycles. It can be paused and restarted, and status bits report a paused erase and a paused word write separately.

The storage is a small internal word memory. It is split into equal blocks of 2^BLK_OFS words, and the upper address bits select the block. The command code is always the low byte of the written word. Reads are combinational from `rd_addr`. The memory has no reset, so its contents survive the reset input.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, any running erase or word write stops without changing the array. Afterwards the status register reads 0x80, reads return array data, and the array keeps its contents.
- R2: Command code FFh selects array reads. Code 90h selects identifier reads: `rd_addr` bit 0 = 0 returns MFR_CODE and bit 0 = 1 returns DEV_CODE. Code 70h selects status reads. Status reads return 0x00 in bits 15:8.
- R3: Code 20h followed by D0h in the same block starts an erase. When it completes, every word of that block reads FFFFh and other blocks are unchanged.
- R4: After a 20h setup, any second cycle that is not D0h in the same block starts nothing. It sets status bit 5 (erase error) and bit 3 (sequence error), and these bits stay set until cleared.
- R5: Code 40h or 10h followed by a data cycle starts a word write. When it completes, the word at the data cycle's address holds its old value ANDed with the new data.
- R6: Status bit 7 reads 0 for exactly ERASE_CYC clock cycles after the erase confirm, or PROG_CYC cycles after the word-write data cycle, and then reads 1. Bits 1:0 always read 0.
- R7: Code B0h during a running erase pauses it. Status bit 6 then reads 1 and bit 7 reads 1, and the remaining erase time is held while paused.
- R8: Code B0h during a running word write pauses it. Status bit 2 then reads 1 and bit 7 reads 1. While paused, only FFh, 70h and D0h take effect.
- R9: Code D0h while paused resumes the operation. The pause bit and bit 7 clear on the next cycle, and the operation then finishes its remaining time.
- R10: While an erase is paused, only FFh, 70h, 40h/10h and D0h take effect. A word write inside the paused block does not run and sets status bit 4. A word write to another block runs, and bit 6 stays set throughout.
- R11: After 20h, 40h, 10h, 70h, 50h, B0h or D0h, reads return the status register until another mode-changing command is written. An unknown code leaves the read mode unchanged.
- R12: Code 50h, written while the engine is idle, clears status bits 5, 4 and 3.
- R13: Only bits 7:0 of a command word are decoded. While an operation is running and not paused, every write except B0h is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write cycle |
| wr_data | input | DATA_W | Command code in bits 7:0, or word-write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array word, status register or identifier code |

## Verification
The read mode, status bits and pause flags are registered on the edge that takes the write. They are therefore visible on `rd_data` one half-cycle later. The bench drives on falling edges and samples on the following falling edge after a short settle delay. Busy lasts exactly ERASE_CYC or PROG_CYC cycles counted from the confirming edge. The bench checks the last busy sample and the first ready sample, with no tolerance. When a paused operation resumes, the bench waits a full operation length, because any duration at least as long as the remaining time is correct.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        CS_IDLE        = 2'd0,
        CS_ERASE_SETUP = 2'd1,
        CS_PROG_SETUP  = 2'd2
    } cmd_state_e;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_READ_ID    = 8'h90;
    localparam logic [7:0] OP_READ_SR    = 8'h70;
    localparam logic [7:0] OP_CLEAR_SR   = 8'h50;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_PROG_A     = 8'h40;
    localparam logic [7:0] OP_PROG_B     = 8'h10;
    localparam logic [7:0] OP_SUSPEND    = 8'hB0;

endpackage

// File: rtl/fcc_timer.sv
module fcc_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CNT_W'(LEN - 1);
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter int ADDR_W  = 6,
    parameter int BLK_OFS = 3,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      erase_en,
    input  logic [ADDR_W-BLK_OFS-1:0] erase_blk,
    input  logic                      prog_en,
    input  logic [ADDR_W-1:0]         prog_addr,
    input  logic [DATA_W-1:0]         prog_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    // Non-volatile storage: deliberately not touched by reset.
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_en && (i >> BLK_OFS) == int'(erase_blk))
                mem[i] <= '1;
            else if (prog_en && i == int'(prog_addr))
                mem[i] <= mem[i] & prog_data;
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          BLK_OFS   = 3,
    parameter int          DATA_W    = 16,
    parameter int          ERASE_CYC = 20,
    parameter int          PROG_CYC  = 5,
    parameter logic [15:0] MFR_CODE  = 16'h00A7,
    parameter logic [15:0] DEV_CODE  = 16'h3C5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BLK_W = ADDR_W - BLK_OFS;

    typedef struct packed {
        rd_mode_e          mode;
        cmd_state_e        cmd;
        logic [BLK_W-1:0]  setup_blk;
        logic              er_act;
        logic              er_susp;
        logic [BLK_W-1:0]  er_blk;
        logic              pg_act;
        logic              pg_susp;
        logic [ADDR_W-1:0] pg_addr;
        logic [DATA_W-1:0] pg_data;
        logic              err_erase;
        logic              err_write;
        logic              err_seq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             er_run, pg_run, er_done, pg_done, er_load, pg_load, ready;
    logic [7:0]       op;
    logic [BLK_W-1:0] wr_blk;
    logic [7:0]       sr_w;
    logic             cmd_idle_w;
    logic [DATA_W-1:0] arr_word;

    assign op     = wr_data[7:0];
    assign wr_blk = wr_addr[ADDR_W-1:BLK_OFS];
    assign er_run = ctl_q.er_act && !ctl_q.er_susp && !ctl_q.pg_act;
    assign pg_run = ctl_q.pg_act && !ctl_q.pg_susp;
    assign ready  = !(er_run || pg_run);
    assign sr_w   = {ready, ctl_q.er_susp, ctl_q.err_erase, ctl_q.err_write,
                     ctl_q.err_seq, ctl_q.pg_susp, 2'b00};
    assign cmd_idle_w = (ctl_q.cmd == CS_IDLE);

    fcc_timer #(.LEN(ERASE_CYC)) u_er_tmr (
        .clk(clk), .rst_n(rst_n), .load(er_load), .run(er_run), .done(er_done)
    );

    fcc_timer #(.LEN(PROG_CYC)) u_pg_tmr (
        .clk(clk), .rst_n(rst_n), .load(pg_load), .run(pg_run), .done(pg_done)
    );

    fcc_array #(.ADDR_W(ADDR_W), .BLK_OFS(BLK_OFS), .DATA_W(DATA_W)) u_array (
        .clk(clk),
        .erase_en(er_done), .erase_blk(ctl_q.er_blk),
        .prog_en(pg_done), .prog_addr(ctl_q.pg_addr), .prog_data(ctl_q.pg_data),
        .rd_addr(rd_addr), .rd_word(arr_word)
    );

    always_comb begin
        ctl_d   = ctl_q;
        er_load = 1'b0;
        pg_load = 1'b0;
        if (er_done) ctl_d.er_act = 1'b0;
        if (pg_done) ctl_d.pg_act = 1'b0;

        if (wr_en) begin
            if (ctl_q.cmd == CS_PROG_SETUP) begin
                // data cycle of a word write
                ctl_d.cmd  = CS_IDLE;
                ctl_d.mode = RD_STATUS;
                if (ctl_q.er_susp && wr_blk == ctl_q.er_blk) begin
                    ctl_d.err_write = 1'b1;
                end else begin
                    ctl_d.pg_act  = 1'b1;
                    ctl_d.pg_addr = wr_addr;
                    ctl_d.pg_data = wr_data;
                    pg_load       = 1'b1;
                end
            end else if (ctl_q.cmd == CS_ERASE_SETUP) begin
                ctl_d.cmd  = CS_IDLE;
                ctl_d.mode = RD_STATUS;
                if (op == OP_CONFIRM && wr_blk == ctl_q.setup_blk) begin
                    ctl_d.er_act = 1'b1;
                    ctl_d.er_blk = wr_blk;
                    er_load      = 1'b1;
                end else begin
                    ctl_d.err_erase = 1'b1;
                    ctl_d.err_seq   = 1'b1;
                end
            end else if (!ready) begin
                // running: only suspend is honoured, never a nested one
                if (op == OP_SUSPEND && !er_done && !pg_done) begin
                    ctl_d.mode = RD_STATUS;
                    if (pg_run && !ctl_q.er_susp) ctl_d.pg_susp = 1'b1;
                    else if (er_run)              ctl_d.er_susp = 1'b1;
                end
            end else if (ctl_q.pg_susp) begin
                case (op)
                    OP_READ_ARRAY: ctl_d.mode = RD_ARRAY;
                    OP_READ_SR:    ctl_d.mode = RD_STATUS;
                    OP_CONFIRM: begin
                        ctl_d.pg_susp = 1'b0;
                        ctl_d.mode    = RD_STATUS;
                    end
                    default: ;
                endcase
            end else if (ctl_q.er_susp) begin
                case (op)
                    OP_READ_ARRAY: ctl_d.mode = RD_ARRAY;
                    OP_READ_SR:    ctl_d.mode = RD_STATUS;
                    OP_PROG_A, OP_PROG_B: begin
                        ctl_d.cmd  = CS_PROG_SETUP;
                        ctl_d.mode = RD_STATUS;
                    end
                    OP_CONFIRM: begin
                        ctl_d.er_susp = 1'b0;
                        ctl_d.mode    = RD_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                case (op)
                    OP_READ_ARRAY: ctl_d.mode = RD_ARRAY;
                    OP_READ_ID:    ctl_d.mode = RD_IDENT;
                    OP_READ_SR:    ctl_d.mode = RD_STATUS;
                    OP_CLEAR_SR: begin
                        ctl_d.err_erase = 1'b0;
                        ctl_d.err_write = 1'b0;
                        ctl_d.err_seq   = 1'b0;
                        ctl_d.mode      = RD_STATUS;
                    end
                    OP_ERASE: begin
                        ctl_d.cmd       = CS_ERASE_SETUP;
                        ctl_d.setup_blk = wr_blk;
                        ctl_d.mode      = RD_STATUS;
                    end
                    OP_PROG_A, OP_PROG_B: begin
                        ctl_d.cmd  = CS_PROG_SETUP;
                        ctl_d.mode = RD_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (ctl_q.mode)
            RD_STATUS: rd_data = {{(DATA_W-8){1'b0}}, sr_w};
            RD_IDENT:  rd_data = rd_addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
            default:   rd_data = arr_word;
        endcase
    end
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_op,
    input logic       cmd_idle,
    input logic [7:0] sr
);
    AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sr == 8'h80);                                   // R1

    AST_SUSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr[6] && sr[2]));                                              // R8

    AST_WSUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sr[2] |-> sr[7]);                                                // R8

    AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 8'hD0 && sr[2]) |=> (!sr[7] && !sr[2]));      // R9

    AST_ESUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[6] && !(wr_en && wr_op == 8'hD0)) |=> sr[6]);                // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[5] && !(wr_en && wr_op == 8'h50)) |=> sr[5]);                // R4

    AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 8'h50 && cmd_idle && sr[7] && !sr[6] && !sr[2])
        |=> sr[5:3] == 3'b000);                                          // R12
endmodule

bind flash_cmd_ctrl fcc_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_data[7:0]),
    .cmd_idle(cmd_idle_w), .sr(sr_w)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
    localparam int ECYC = 12;
    localparam int PCYC = 6;
    localparam logic [15:0] MFR = 16'h00A7;
    localparam logic [15:0] DEV = 16'h3C5E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(6), .BLK_OFS(3), .DATA_W(16), .ERASE_CYC(ECYC), .PROG_CYC(PCYC),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {pad3, write, waddr6, wdata16, wait8, raddr6, req8, expect16}
    localparam int NV = 17;
    localparam logic [63:0] VEC [NV] = '{
        {3'b0, 1'b1, 6'd0, 16'h00FF, 8'd0, 6'd0, 8'd2,  16'hFFFF}, // R2 array
        {3'b0, 1'b1, 6'd0, 16'h0090, 8'd0, 6'd0, 8'd2,  MFR},      // R2 ident
        {3'b0, 1'b0, 6'd0, 16'h0000, 8'd0, 6'd1, 8'd2,  DEV},      // R2 ident bit0
        {3'b0, 1'b1, 6'd0, 16'h0070, 8'd0, 6'd5, 8'd2,  16'h0080}, // R2 status
        {3'b0, 1'b1, 6'd0, 16'h00FF, 8'd0, 6'd6, 8'd2,  16'hFFFF}, // R2
        {3'b0, 1'b1, 6'd0, 16'h5590, 8'd0, 6'd0, 8'd13, MFR},      // R13 high byte
        {3'b0, 1'b1, 6'd0, 16'h0033, 8'd0, 6'd1, 8'd11, DEV},      // R11 unknown
        {3'b0, 1'b1, 6'd0, 16'h0070, 8'd0, 6'd0, 8'd11, 16'h0080}, // R11
        {3'b0, 1'b1, 6'd0, 16'h0050, 8'd0, 6'd0, 8'd11, 16'h0080}, // R11 50h
        {3'b0, 1'b1, 6'd3, 16'h0040, 8'd0, 6'd3, 8'd11, 16'h0080}, // R11 setup
        {3'b0, 1'b1, 6'd3, 16'h5A5A, 8'd0, 6'd3, 8'd6,  16'h0000}, // R6 busy
        {3'b0, 1'b0, 6'd0, 16'h0000, 8'd5, 6'd3, 8'd6,  16'h0000}, // R6 last busy
        {3'b0, 1'b0, 6'd0, 16'h0000, 8'd1, 6'd3, 8'd6,  16'h0080}, // R6 ready
        {3'b0, 1'b1, 6'd0, 16'h00FF, 8'd0, 6'd3, 8'd5,  16'h5A5A}, // R5
        {3'b0, 1'b1, 6'd3, 16'h0010, 8'd0, 6'd3, 8'd5,  16'h0080}, // R5 10h
        {3'b0, 1'b1, 6'd3, 16'h0FF0, 8'd6, 6'd3, 8'd5,  16'h0080}, // R5
        {3'b0, 1'b1, 6'd0, 16'h00FF, 8'd0, 6'd3, 8'd5,  16'h0A50}  // R5 AND
    };

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [5:0] ra, input logic [15:0] exp);
        rd_addr = ra;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_err++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, ra, rd_data, exp);
        end
    endtask

    task automatic erase(input logic [5:0] a);
        wr(a, 16'h0020);
        wr(a, 16'h00D0);
        idle(ECYC);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: status after reset
        wr(6'd0, 16'h0070);
        chk("R1", 0, 16'h0080);

        // R3, R6: erase block 0 with exact busy window
        wr(6'd0, 16'h0020);
        chk("R11", 0, 16'h0080);
        wr(6'd0, 16'h00D0);
        chk("R6", 0, 16'h0000);
        idle(ECYC - 1);
        chk("R6", 0, 16'h0000);
        idle(1);
        chk("R6", 0, 16'h0080);
        wr(6'd0, 16'h00FF);
        chk("R3", 0, 16'hFFFF);
        chk("R3", 7, 16'hFFFF);

        // table walk: read modes and word writes
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][60]) wr(VEC[i][59:54], VEC[i][53:38]);
            idle(int'(VEC[i][37:30]));
            chk($sformatf("R%0d", VEC[i][23:16]), VEC[i][29:24], VEC[i][15:0]);
        end

        // R3: erase of block 1 leaves block 0 alone
        erase(6'd8);
        erase(6'd16);
        wr(6'd0, 16'h00FF);
        chk("R3", 8, 16'hFFFF);
        chk("R3", 3, 16'h0A50);

        // R4: invalid confirm sequences
        wr(6'd16, 16'h0040);
        wr(6'd16, 16'h00F0);
        idle(PCYC);
        wr(6'd16, 16'h0020);
        wr(6'd16, 16'h00FF);
        chk("R4", 0, 16'h00A8);
        idle(ECYC);
        wr(6'd0, 16'h00FF);
        chk("R4", 16, 16'h00F0);
        wr(6'd0, 16'h0020);
        wr(6'd8, 16'h00D0);
        chk("R4", 0, 16'h00A8);
        wr(6'd0, 16'h0050);
        chk("R12", 0, 16'h0080);

        // R7, R9, R10, R13: erase suspend with nested word write
        wr(6'd9, 16'h0040);
        wr(6'd9, 16'h1234);
        idle(PCYC);
        wr(6'd8, 16'h0020);
        wr(6'd8, 16'h00D0);
        idle(2);
        wr(6'd0, 16'h00FF);
        chk("R13", 0, 16'h0000);
        wr(6'd0, 16'h00B0);
        chk("R7", 0, 16'h00C0);
        idle(30);
        chk("R7", 0, 16'h00C0);
        wr(6'd0, 16'h00FF);
        chk("R10", 9, 16'h1234);
        wr(6'd0, 16'h0090);
        chk("R10", 9, 16'h1234);
        wr(6'd0, 16'h0020);
        wr(6'd10, 16'h0040);
        wr(6'd10, 16'h0000);
        chk("R10", 0, 16'h00D0);
        wr(6'd0, 16'h00FF);
        chk("R10", 10, 16'hFFFF);
        wr(6'd2, 16'h0040);
        wr(6'd2, 16'h00FF);
        chk("R10", 0, 16'h0050);
        idle(PCYC);
        chk("R10", 0, 16'h00D0);
        wr(6'd0, 16'h00D0);
        chk("R9", 0, 16'h0010);
        idle(ECYC);
        chk("R9", 0, 16'h0090);
        wr(6'd0, 16'h00FF);
        chk("R9", 9, 16'hFFFF);
        chk("R10", 2, 16'h00FF);
        wr(6'd0, 16'h0050);
        chk("R12", 0, 16'h0080);

        // R8, R9: word-write suspend
        wr(6'd4, 16'h0040);
        wr(6'd4, 16'h1111);
        chk("R6", 0, 16'h0000);
        wr(6'd0, 16'h00B0);
        chk("R8", 0, 16'h0084);
        wr(6'd5, 16'h0040);
        wr(6'd5, 16'h0000);
        chk("R8", 0, 16'h0084);
        wr(6'd0, 16'h00FF);
        chk("R8", 5, 16'hFFFF);
        wr(6'd0, 16'h00D0);
        chk("R9", 0, 16'h0000);
        idle(PCYC);
        chk("R9", 0, 16'h0080);
        wr(6'd0, 16'h00FF);
        chk("R5", 4, 16'h1111);

        // R1: reset aborts a running erase and clears error bits
        wr(6'd16, 16'h0020);
        wr(6'd16, 16'h0000);
        wr(6'd16, 16'h0020);
        wr(6'd16, 16'h00D0);
        idle(2);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        chk("R1", 16, 16'h00F0);
        chk("R1", 3, 16'h0A50);
        wr(6'd0, 16'h0070);
        chk("R1", 0, 16'h0080);

        finish_run();
    end
endmodule